// File: doc/BRIEF.md
# Vector Memory Access Fault Checker

This block vets a vector load or store before the scalar pipeline may continue past it. A command gives a base byte address, a byte stride, an element size of 4 or 8 bytes and an element count. The block walks the element addresses in element order. It returns one verdict: either go, or fault with the address, the element index and a cause word for the first element that breaks a rule. An element breaks a rule when its address is not a multiple of the element size, or when it lies in the I/O region. That region is every address at or above the parameter `IO_BASE`.

The command port and the verdict port each use a valid/ready handshake. Only one command is in flight at a time. `cmd_ready` is high only when no command is being checked and no verdict is waiting. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The verdict is offered on `rsp_valid` and stays fixed until the edge where `rsp_ready` is high. The scalar side holds its issue stage from the moment it hands over the command until it takes the verdict. A fault verdict can therefore be raised as a precise exception.

A unit-stride access has a stride equal to plus the element size. For such an access the verdict comes from the base and the last address in one step. Any other stride is checked one element per clock. Addresses are computed modulo 2^AW.

Top module: `vmem_fault_chk`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: `cmd_ready` is 0 from the accepting edge until the edge that takes the verdict. A `cmd_valid` seen while `cmd_ready` is 0 does not change the verdict being worked on. `cmd_ready` is 1 again in the cycle after the verdict is taken.
- R3: An element whose address is not a multiple of its size gives a fault with bit 3 of `rsp_param` set. `cmd_dw` selects the size: 0 means 4 bytes, 1 means 8 bytes.
- R4: An element whose address is at or above `IO_BASE` gives a fault with bit 2 of `rsp_param` set. Bits 3 and 2 can both be set for one element. Bits 1:0 are always 0.
- R5: On a fault, `rsp_fault` is 1. `rsp_addr` and `rsp_elem` give the address and index of the lowest-indexed faulting element, and `rsp_param` gives that element's causes alone.
- R6: A unit-stride command (stride equal to +4 with `cmd_dw`=0, or +8 with `cmd_dw`=1) has its verdict on `rsp_valid` in the cycle right after acceptance, for any element count.
- R7: For any other stride, element j is checked in the j-th cycle after acceptance, counting from 0. `rsp_valid` rises j+1 edges after the accepting edge, where j is the faulting element or the last element.
- R8: A command with element count 0 gives a go verdict in the cycle after acceptance, whatever its base.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_fault`, `rsp_param`, `rsp_addr` and `rsp_elem` hold their values.
- R10: A go verdict has `rsp_fault`, `rsp_param`, `rsp_addr` and `rsp_elem` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_base | input | AW | Address of element 0 |
| cmd_stride | input | AW | Byte distance between elements, two's complement |
| cmd_dw | input | 1 | Element size: 0 = 4 bytes, 1 = 8 bytes |
| cmd_vlen | input | LW | Number of elements |
| rsp_valid | output | 1 | Verdict offered |
| rsp_ready | input | 1 | Verdict taken |
| rsp_fault | output | 1 | 1 = fault, 0 = go |
| rsp_param | output | 4 | Cause word: bit 3 alignment, bit 2 I/O region, bits 1:0 zero |
| rsp_addr | output | AW | Address of the faulting element |
| rsp_elem | output | LW | Index of the faulting element |

## Verification
Some properties are checked on every cycle by assertions:
- the verdict holds under back-pressure;
- the command port stays closed while a verdict is pending;
- a go verdict carries all-zero fields, and a fault always names a cause;
- unit-stride and empty commands answer in the next cycle.

Other behaviour is only shown by the bench's scenarios, which compare against a behavioural model:
- which element is reported first, with its address and index;
- the cause bits for misaligned, I/O and combined cases;
- address wrap with negative strides;
- the exact per-element latency of the strided walk;
- the fast-path result for an I/O region that starts partway through a unit-stride vector.

// File: rtl/vmf_pkg.sv
package vmf_pkg;

  localparam int PW       = 4;
  localparam int PB_IO    = 2;
  localparam int PB_ALIGN = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } vmf_state_e;

  typedef struct packed {
    logic align;
    logic io;
  } vmf_cause_t;

  function automatic logic [PW-1:0] cause_to_param(input vmf_cause_t c);
    logic [PW-1:0] p;
    p = '0;
    p[PB_ALIGN] = c.align;
    p[PB_IO]    = c.io;
    return p;
  endfunction

endpackage

// File: rtl/vmf_elem_check.sv
module vmf_elem_check #(
  parameter int          AW      = 32,
  parameter logic [AW-1:0] IO_BASE = 32'hF000_0000
) (
  input  logic [AW-1:0]      addr,
  input  logic               dw,
  output vmf_pkg::vmf_cause_t cause
);
  // Alignment depends on the element size; the I/O region is an upper range.
  always_comb begin
    cause.align = dw ? (|addr[2:0]) : (|addr[1:0]);
    cause.io    = (addr >= IO_BASE);
  end
endmodule

// File: rtl/vmf_unit_eval.sv
module vmf_unit_eval #(
  parameter int            AW      = 32,
  parameter int            LW      = 7,
  parameter logic [AW-1:0] IO_BASE = 32'hF000_0000
) (
  input  logic                  [AW-1:0] base,
  input  logic                           dw,
  input  logic                  [LW-1:0] vlen,
  output logic                           fault,
  output logic [vmf_pkg::PW-1:0]         param,
  output logic                  [AW-1:0] addr,
  output logic                  [LW-1:0] elem
);
  import vmf_pkg::*;

  localparam int EW = AW + 1;

  vmf_cause_t    c0;
  logic [EW-1:0] span;
  logic [EW-1:0] last_ext;
  logic [AW-1:0] gap;
  logic [AW-1:0] gap_idx;
  logic          first_bad;
  logic          cross_io;

  vmf_elem_check #(.AW(AW), .IO_BASE(IO_BASE)) u_first (
    .addr  (base),
    .dw    (dw),
    .cause (c0)
  );

  always_comb begin
    // Byte span from element 0 to the last element, kept one bit wider so
    // a wrap past the top still compares as beyond the I/O boundary.
    span     = EW'(vlen - LW'(1)) << (dw ? 3 : 2);
    last_ext = {1'b0, base} + span;
    first_bad = c0.align | c0.io;
    // Base is aligned and below the boundary, so every element is aligned
    // and the first one in the region lands exactly on IO_BASE.
    cross_io = !first_bad && (last_ext >= {1'b0, IO_BASE});
    gap      = IO_BASE - base;
    gap_idx  = dw ? (gap >> 3) : (gap >> 2);
    fault    = first_bad | cross_io;
    if (first_bad) begin
      param = cause_to_param(c0);
      addr  = base;
      elem  = '0;
    end else if (cross_io) begin
      param = cause_to_param('{align: 1'b0, io: 1'b1});
      addr  = IO_BASE;
      elem  = gap_idx[LW-1:0];
    end else begin
      param = '0;
      addr  = '0;
      elem  = '0;
    end
  end
endmodule

// File: rtl/vmem_fault_chk.sv
module vmem_fault_chk #(
  parameter int            AW        = 32,
  parameter int            LW        = 7,
  parameter logic [AW-1:0] IO_BASE   = 32'hF000_0000,
  parameter bit            UNIT_FAST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_stride,
  input  logic          cmd_dw,
  input  logic [LW-1:0] cmd_vlen,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_fault,
  output logic [3:0]    rsp_param,
  output logic [AW-1:0] rsp_addr,
  output logic [LW-1:0] rsp_elem
);
  import vmf_pkg::*;

  vmf_state_e    state;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] stride_q;
  logic          dw_q;
  logic [LW-1:0] idx_q;
  logic [LW-1:0] last_q;

  logic          accept;
  logic          is_unit;
  logic          fast_take;
  logic          fu_fault;
  logic [PW-1:0] fu_param;
  logic [AW-1:0] fu_addr;
  logic [LW-1:0] fu_elem;
  vmf_cause_t    wc;

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = cmd_valid && cmd_ready;
  assign is_unit   = (cmd_stride == (cmd_dw ? AW'(8) : AW'(4)));

  generate
    if (UNIT_FAST) begin : g_fast
      vmf_unit_eval #(.AW(AW), .LW(LW), .IO_BASE(IO_BASE)) u_unit (
        .base  (cmd_base),
        .dw    (cmd_dw),
        .vlen  (cmd_vlen),
        .fault (fu_fault),
        .param (fu_param),
        .addr  (fu_addr),
        .elem  (fu_elem)
      );
      assign fast_take = is_unit;
    end else begin : g_walk_only
      assign fu_fault  = 1'b0;
      assign fu_param  = '0;
      assign fu_addr   = '0;
      assign fu_elem   = '0;
      assign fast_take = 1'b0;
    end
  endgenerate

  vmf_elem_check #(.AW(AW), .IO_BASE(IO_BASE)) u_walk (
    .addr  (cur_addr),
    .dw    (dw_q),
    .cause (wc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      stride_q  <= '0;
      dw_q      <= 1'b0;
      idx_q     <= '0;
      last_q    <= '0;
      rsp_fault <= 1'b0;
      rsp_param <= '0;
      rsp_addr  <= '0;
      rsp_elem  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (cmd_vlen == '0) begin
              state     <= ST_RESP;
              rsp_fault <= 1'b0;
              rsp_param <= '0;
              rsp_addr  <= '0;
              rsp_elem  <= '0;
            end else if (fast_take) begin
              state     <= ST_RESP;
              rsp_fault <= fu_fault;
              rsp_param <= fu_param;
              rsp_addr  <= fu_addr;
              rsp_elem  <= fu_elem;
            end else begin
              state    <= ST_WALK;
              cur_addr <= cmd_base;
              stride_q <= cmd_stride;
              dw_q     <= cmd_dw;
              idx_q    <= '0;
              last_q   <= cmd_vlen - LW'(1);
            end
          end
        end
        ST_WALK: begin
          if (wc.align || wc.io) begin
            state     <= ST_RESP;
            rsp_fault <= 1'b1;
            rsp_param <= cause_to_param(wc);
            rsp_addr  <= cur_addr;
            rsp_elem  <= idx_q;
          end else if (idx_q == last_q) begin
            state     <= ST_RESP;
            rsp_fault <= 1'b0;
            rsp_param <= '0;
            rsp_addr  <= '0;
            rsp_elem  <= '0;
          end else begin
            cur_addr <= cur_addr + stride_q;
            idx_q    <= idx_q + LW'(1);
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vmf_fault_chk_sva.sv
module vmf_fault_chk_sva #(
  parameter int AW        = 32,
  parameter int LW        = 7,
  parameter bit UNIT_FAST = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] cmd_stride,
  input logic          cmd_dw,
  input logic [LW-1:0] cmd_vlen,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_fault,
  input logic [3:0]    rsp_param,
  input logic [AW-1:0] rsp_addr,
  input logic [LW-1:0] rsp_elem
);
  logic take;
  logic unit_cmd;
  assign take     = cmd_valid && cmd_ready;
  assign unit_cmd = UNIT_FAST && (cmd_stride == (cmd_dw ? AW'(8) : AW'(4)));

  assert_port_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) &&
      $stable(rsp_param) && $stable(rsp_addr) && $stable(rsp_elem));

  assert_go_is_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_param == 4'd0 && rsp_addr == '0 && rsp_elem == '0);

  // R3 and R4: a fault always names at least one cause, never a low bit.
  assert_fault_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_param[3:2] != 2'b00 && rsp_param[1:0] == 2'b00);

  assert_unit_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && unit_cmd |=> rsp_valid);

  assert_empty_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_vlen == '0 |=> rsp_valid && !rsp_fault);
endmodule

bind vmem_fault_chk vmf_fault_chk_sva #(.AW(AW), .LW(LW), .UNIT_FAST(UNIT_FAST)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_stride (cmd_stride),
  .cmd_dw     (cmd_dw),
  .cmd_vlen   (cmd_vlen),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_fault  (rsp_fault),
  .rsp_param  (rsp_param),
  .rsp_addr   (rsp_addr),
  .rsp_elem   (rsp_elem)
);

// File: tb/sim_vmem_fault_chk.sv
`timescale 1ns/1ps
module sim_vmem_fault_chk;
  localparam int          AW = 32;
  localparam int          LW = 7;
  localparam int unsigned IOB = 32'hF000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_base = '0;
  logic [AW-1:0] cmd_stride = '0;
  logic          cmd_dw = 1'b0;
  logic [LW-1:0] cmd_vlen = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_fault;
  logic [3:0]    rsp_param;
  logic [AW-1:0] rsp_addr;
  logic [LW-1:0] rsp_elem;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vmem_fault_chk #(.AW(AW), .LW(LW), .IO_BASE(IOB), .UNIT_FAST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_dw(cmd_dw), .cmd_vlen(cmd_vlen),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_param(rsp_param), .rsp_addr(rsp_addr), .rsp_elem(rsp_elem)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: walk elements in order, wrap modulo 2^32.
  function automatic void ref_model(input int unsigned base, input int unsigned stride,
                                    input bit dw, input int vlen, output int lat,
                                    output bit f, output int unsigned addr,
                                    output bit [3:0] par, output int idx);
    int unsigned esz;
    int unsigned a;
    bit al;
    bit io;
    esz = dw ? 8 : 4;
    f = 0; addr = 0; par = 0; idx = 0;
    if (vlen == 0) begin
      lat = 1;
      return;
    end
    a = base;
    for (int i = 0; i < vlen; i++) begin
      al = (a % esz) != 0;
      io = a >= IOB;
      if (al || io) begin
        f = 1; addr = a; par = {al, io, 2'b00}; idx = i;
        break;
      end
      a = a + stride;
    end
    if (stride == esz) lat = 1;
    else lat = f ? idx + 2 : vlen + 1;
  endfunction

  task automatic run(input string name, input int unsigned base, input int unsigned stride,
                     input bit dw, input int vlen, input int stall, input bit intrude);
    int lat; bit ef; int unsigned ea; bit [3:0] ep; int ei;
    logic [3:0] p0; logic [AW-1:0] a0; logic [LW-1:0] e0;
    ref_model(base, stride, dw, vlen, lat, ef, ea, ep, ei);
    @(negedge clk);
    check(cmd_ready == 1'b1, {"R2 idle ready ", name}, cmd_ready, 1);
    cmd_base = base; cmd_stride = stride; cmd_dw = dw; cmd_vlen = LW'(vlen);
    cmd_valid = 1'b1;
    @(posedge clk);
    #1;
    if (intrude) begin
      cmd_base = 32'h0000_0002; cmd_stride = 32'd4; cmd_dw = 1'b0; cmd_vlen = LW'(9);
    end else cmd_valid = 1'b0;
    for (int n = 1; n <= lat; n++) begin
      @(negedge clk);
      // R6 / R7: verdict appears exactly at the modelled cycle.
      check(rsp_valid == (n >= lat), {"R7 R6 timing ", name}, rsp_valid, n >= lat);
      if (n < lat) check(cmd_ready == 1'b0, {"R2 busy ", name}, cmd_ready, 0);
      if (rsp_valid !== (n >= lat)) break;
    end
    // R5 R3 R4 R10 R8: verdict contents.
    check(rsp_fault == ef, {"R5 fault ", name}, rsp_fault, ef);
    check(rsp_param == ep, {"R3 R4 param ", name}, rsp_param, ep);
    check(rsp_addr == ea, {"R5 addr ", name}, rsp_addr, ea);
    check(rsp_elem == LW'(ei), {"R5 elem ", name}, rsp_elem, ei);
    p0 = rsp_param; a0 = rsp_addr; e0 = rsp_elem;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_param == p0 && rsp_addr == a0 && rsp_elem == e0,
            {"R9 hold ", name}, {rsp_valid, rsp_addr}, {1'b1, a0});
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
    @(negedge clk);
    check(!rsp_valid && cmd_ready, {"R2 released ", name}, {rsp_valid, cmd_ready}, 2'b01);
  endtask

  initial begin
    #3;
    check(rsp_valid == 1'b0, "R1 reset valid", rsp_valid, 0);
    check(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    #10 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R1 after reset", {rsp_valid, cmd_ready}, 2'b01);
    run("unit4 go R6",        32'h0000_1000, 32'd4,          1'b0, 16, 0, 1'b0);
    run("unit8 misalign R3",  32'h0000_1004, 32'd8,          1'b1, 5,  2, 1'b0);
    run("unit4 io cross R4",  32'hEFFF_FFF0, 32'd4,          1'b0, 8,  0, 1'b0);
    run("unit8 io base R4",   32'hF000_0100, 32'd8,          1'b1, 3,  0, 1'b0);
    run("unit4 both R3 R4",   32'hF000_0002, 32'd4,          1'b0, 4,  1, 1'b0);
    run("unit8 long R6",      32'h0000_0000, 32'd8,          1'b1, 127, 0, 1'b0);
    run("stride12 go R7",     32'h0000_2000, 32'd12,         1'b0, 10, 0, 1'b1);
    run("stride6 elem1 R5",   32'h0000_0100, 32'd6,          1'b0, 5,  3, 1'b0);
    run("neg8 wrap R4",       32'h0000_0040, 32'hFFFF_FFF8,  1'b1, 20, 0, 1'b0);
    run("empty R8",           32'h0000_0003, 32'd4,          1'b0, 0,  2, 1'b0);
    run("neg4 go R7",         32'h0000_0100, 32'hFFFF_FFFC,  1'b0, 4,  0, 1'b0);
    run("zero stride R7",     32'h0000_0008, 32'd0,          1'b1, 6,  0, 1'b1);
    run("stride16 io R5",     32'hEFFF_FFF8, 32'd16,         1'b1, 4,  0, 1'b0);
    run("stride8 dw0 R3",     32'h0000_0006, 32'd8,          1'b0, 3,  0, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule